// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block lets a host manage external Ethernet PHYs over the two-wire MDIO management interface. The host sees three 16-bit registers on a simple synchronous register port: a control word, a transmit data word and a receive data word. Writing a valid command into the control word both describes a Clause 22 transaction and launches it. The host then polls an idle flag in the same control word until the transaction has finished.

For a write, the host loads the 16-bit payload into the transmit data word first and then writes the control word. For a read, the 16 bits returned by the PHY appear in the receive data word when the frame ends. The management clock is derived from the system clock by a parameterised divider. The default divider gives 2.5 MHz from a 50 MHz clock.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 0x1000 (idle flag set, command field zero), the management clock is low, the data pin output enable is low, and the receive data word reads zero.
- R2: The control word is at byte offset 0x0, the transmit data word at 0x2 and the receive data word at 0x4. The transmit data word reads back what was last written to it, and any other offset reads zero.
- R3: In the control word, bits [4:0] are the PHY register number, bits [9:5] the PHY address and bits [11:10] the opcode (2 = read, 1 = write). Bit 12 reads 1 when idle and 0 while a frame runs. Bits [11:0] read back the last accepted command.
- R4: Each frame is 64 bit times, sent MSB first: 32 ones, start code 01, opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register number, 2 turnaround bits and 16 data bits.
- R5: The management clock has a period of 2*MDC_HALF_DIV system clocks and stays low while idle. A frame keeps the block busy for exactly 128*MDC_HALF_DIV clocks, counted from the clock edge that accepts the control write.
- R6: A write frame drives turnaround 10 followed by the transmit data word, and keeps the output enable high for all 64 bits.
- R7: A read frame releases the output enable from bit 46 (the first turnaround bit) to the end of the frame. It samples the data pin on each rising management clock edge of the 16 data bits and loads the result into the receive data word when the frame ends.
- R8: A control write that arrives while a frame runs is ignored. No new frame starts and the command field does not change.
- R9: A control write with opcode 0 or 3 starts no frame and leaves the command field unchanged.
- R10: A write frame leaves the receive data word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The bench plays the PHY. It records every bit on the rising management clock edge and returns chosen data for reads, including all-ones addresses and a payload with only its LSB set. A design that shifted from the wrong end, swapped the address fields or released the pin one bit late would show a mismatched frame image. A cycle model of the busy window catches a divider or frame length that is off by one. Control writes made during a frame, and writes with the two unused opcodes, are checked against the idle flag and the command readback; a design that accepted them would start an extra frame or corrupt the command. A write frame issued after a read checks that the receive word is not overwritten.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSVD  = 2'b11
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e   op;
    logic [4:0] phy;
    logic [4:0] regn;
  } mdio_cmd_t;

  localparam int ADDR_W     = 3;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'h0;
  localparam logic [ADDR_W-1:0] OFS_TX   = 3'h2;
  localparam logic [ADDR_W-1:0] OFS_RX   = 3'h4;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  assign term = run && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc  = mdc_q;
  assign rise = term && !mdc_q;
  assign fall = term && mdc_q;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] tx_word,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        busy,
  output logic        is_read,
  output logic [5:0]  bit_idx,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] cap_word
);
  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [5:0]            idx_q, idx_d;
  logic [15:0]           cap_q, cap_d;
  logic                  rd_q, rd_d;
  logic                  oe_q, oe_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    cap_d  = cap_q;
    rd_d   = rd_q;
    oe_d   = oe_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = {32'hFFFF_FFFF, 2'b01, cmd.op, cmd.phy, cmd.regn, 2'b10, tx_word};
        idx_d  = '0;
        oe_d   = 1'b1;
        rd_d   = (cmd.op == OP_READ);
        cap_d  = '0;
      end
    end else begin
      if (rise && rd_q && (idx_q >= 6'(DATA_BIT)))
        cap_d = {cap_q[14:0], mdio_i};
      if (fall) begin
        if (idx_q == 6'(FRAME_BITS - 1)) begin
          busy_d = 1'b0;
          oe_d   = 1'b0;
          done   = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
          oe_d  = !(rd_q && (idx_q >= 6'(TA_BIT - 1)));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      cap_q  <= '0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      cap_q  <= cap_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
    end
  end

  assign busy     = busy_q;
  assign is_read  = rd_q;
  assign bit_idx  = idx_q;
  assign mdio_o   = sh_q[FRAME_BITS-1];
  assign mdio_oe  = oe_q;
  assign cap_word = cap_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [15:0]       wdata,
  input  logic              busy,
  input  logic              load_rx,
  input  logic [15:0]       cap_word,
  output logic              start,
  output mdio_cmd_t         cmd,
  output logic [15:0]       tx_word,
  output logic [15:0]       rx_word,
  output logic [15:0]       rdata
);
  mdio_cmd_t   cmd_q, cmd_d;
  logic [15:0] tx_q, tx_d;
  logic [15:0] rx_q, rx_d;
  mdio_cmd_t   wcmd;
  logic        op_ok;

  assign wcmd  = mdio_cmd_t'(wdata[11:0]);
  assign op_ok = (wcmd.op == OP_READ) || (wcmd.op == OP_WRITE);
  assign start = we && (addr == OFS_CTRL) && !busy && op_ok;

  always_comb begin
    cmd_d = cmd_q;
    tx_d  = tx_q;
    rx_d  = rx_q;
    if (start) cmd_d = wcmd;
    if (we && (addr == OFS_TX)) tx_d = wdata;
    if (load_rx) rx_d = cap_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      cmd_q <= cmd_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rdata = {3'b000, !busy, cmd_q};
      OFS_TX:   rdata = tx_q;
      OFS_RX:   rdata = rx_q;
      default:  rdata = '0;
    endcase
  end

  assign cmd     = cmd_q;
  assign tx_word = tx_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF_DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        busy;
  logic        frame_is_rd;
  logic [5:0]  bit_idx;
  logic [15:0] rx_data;
  logic [15:0] tx_data;
  logic [15:0] cap_word;
  mdio_cmd_t   cmd_cur;
  logic        start;
  logic        done;
  logic        mdc_rise;
  logic        mdc_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .busy(busy), .load_rx(done && frame_is_rd), .cap_word(cap_word),
    .start(start), .cmd(cmd_cur), .tx_word(tx_data), .rx_word(rx_data), .rdata(reg_rdata)
  );

  mdio_clkgen #(.HALF_DIV(MDC_HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_int_n), .run(busy), .mdc(mdc), .rise(mdc_rise), .fall(mdc_fall)
  );

  mdio_engine u_engine (
    .clk(clk), .rst_n(rst_int_n), .start(start), .cmd(mdio_cmd_t'(reg_wdata[11:0])),
    .tx_word(tx_data), .rise(mdc_rise), .fall(mdc_fall), .mdio_i(mdio_i),
    .busy(busy), .is_read(frame_is_rd), .bit_idx(bit_idx), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done), .cap_word(cap_word)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        busy,
  input logic        read_op,
  input logic [5:0]  bit_idx,
  input logic [15:0] rx_data,
  input logic [11:0] cmd
);
  // R5
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  // R6
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !read_op) |-> mdio_oe);
  // R7
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && read_op && (bit_idx >= 6'd46)) |-> !mdio_oe);
  // R7
  rx_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> ($fell(busy) && read_op));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && (reg_addr == 3'h0)) |=> $stable(cmd));
  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && (reg_addr == 3'h0) &&
     ((reg_wdata[11:10] == 2'b00) || (reg_wdata[11:10] == 2'b11))) |=> !busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy),
  .read_op(frame_is_rd), .bit_idx(bit_idx), .rx_data(rx_data), .cmd(cmd_cur)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 10;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk;
  logic        rst_n;
  logic [2:0]  reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int tests, fails;

  mdio_master #(.MDC_HALF_DIV(HALF)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model of the busy window, command field and receive word
  int          m_rem;
  logic [11:0] m_cmd;
  logic        m_rd;
  logic [15:0] m_rx;
  logic [15:0] slave_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_cmd = '0; m_rd = 1'b0; m_rx = '0;
    end else if (m_rem == 0) begin
      if (reg_we && reg_addr == 3'h0 &&
          (reg_wdata[11:10] == 2'b01 || reg_wdata[11:10] == 2'b10)) begin
        m_rem = FRAME_CYC;
        m_cmd = reg_wdata[11:0];
        m_rd  = (reg_wdata[11:10] == 2'b10);
      end
    end else begin
      m_rem = m_rem - 1;
      if (m_rem == 0 && m_rd) m_rx = slave_val;
    end
  end

  always @(negedge clk) begin
    if (rst_n && reg_addr == 3'h0 && !reg_we) begin
      // R3 R5 R8 R9: idle flag and command readback follow the model every clock
      check("R5 idle flag", {63'd0, reg_rdata[12]}, {63'd0, m_rem == 0});
      check("R3 cmd field", {52'd0, reg_rdata[11:0]}, {52'd0, m_cmd});
      if (m_rem == 0) check("R5 mdc idle low", {63'd0, mdc}, 64'd0);
    end
  end

  // PHY model
  int          rises;
  logic [63:0] obs_o, obs_oe;
  longint      cyc, first_rise, second_rise;

  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    if (rises < 64) begin
      obs_o[63-rises]  = mdio_o;
      obs_oe[63-rises] = mdio_oe;
    end
    if (rises == 0) first_rise = cyc;
    if (rises == 1) second_rise = cyc;
    rises++;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises < 64) mdio_i = slave_val[63-rises];
    else if (rises == 47) mdio_i = 1'b0;
    else mdio_i = 1'b1;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'h0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_addr = 3'h0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * FRAME_CYC; i++) begin
      @(negedge clk);
      #1;
      if (reg_rdata[12]) break;
    end
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] rn);
    rises = 0; obs_o = '0; obs_oe = '0;
    wr(3'h0, {4'h0, op, phy, rn});
  endtask

  logic [15:0] v;
  logic [63:0] exp_f;

  initial begin
    tests = 0; fails = 0; cyc = 0; rises = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'h0; reg_wdata = '0;
    mdio_i = 1'b1; slave_val = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'h0, v); check("R1 ctrl after reset", {48'd0, v}, 64'h1000);
    rd(3'h4, v); check("R1 rx after reset", {48'd0, v}, 64'h0);
    check("R1 mdc low", {63'd0, mdc}, 64'd0);
    check("R1 oe low", {63'd0, mdio_oe}, 64'd0);

    // R2 register map
    wr(3'h2, 16'hA5C3);
    rd(3'h2, v); check("R2 tx readback", {48'd0, v}, 64'hA5C3);
    rd(3'h6, v); check("R2 unmapped offset", {48'd0, v}, 64'h0);

    // write frame, with an ignored control write mid-frame (R8)
    run_frame(2'b01, 5'h11, 5'h0A);
    repeat (200) @(negedge clk);
    wr(3'h0, {4'h0, 2'b10, 5'h03, 5'h04});
    rd(3'h0, v); check("R8 cmd unchanged while busy", {52'd0, v[11:0]}, {52'd0, 2'b01, 5'h11, 5'h0A});
    wait_idle();
    repeat (3 * HALF) @(negedge clk);
    check("R8 no extra frame", rises, 64);
    exp_f = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h0A, 2'b10, 16'hA5C3};
    check("R4 R6 write frame bits", obs_o, exp_f);
    check("R6 write oe all bits", obs_oe, {64{1'b1}});
    check("R5 mdc period", second_rise - first_rise, 2 * HALF);
    rd(3'h4, v); check("R10 rx after write", {48'd0, v}, 64'h0);

    // read frame, all-ones address
    slave_val = 16'hBEEF;
    run_frame(2'b10, 5'h1F, 5'h1F);
    wait_idle();
    check("R4 read header", {18'd0, obs_o[63:18]}, {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, 5'h1F, 5'h1F});
    check("R7 read oe release", obs_oe, {{46{1'b1}}, 18'd0});
    rd(3'h4, v); check("R7 rx data", {48'd0, v}, 64'hBEEF);

    // read frame, LSB-only payload, zero address
    slave_val = 16'h0001;
    run_frame(2'b10, 5'h00, 5'h03);
    wait_idle();
    check("R4 read header 2", {18'd0, obs_o[63:18]}, {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, 5'h00, 5'h03});
    rd(3'h4, v); check("R7 rx lsb", {48'd0, v}, 64'h0001);

    // R9 unused opcodes
    rises = 0;
    wr(3'h0, {4'h0, 2'b00, 5'h05, 5'h06});
    wr(3'h0, {4'h0, 2'b11, 5'h07, 5'h08});
    repeat (4 * HALF) @(negedge clk);
    check("R9 no frame", rises, 0);
    rd(3'h0, v); check("R9 ctrl unchanged", {48'd0, v}, {48'd0, 4'h1, 2'b10, 5'h00, 5'h03});

    // R10 write after read keeps rx
    wr(3'h2, 16'h8001);
    run_frame(2'b01, 5'h01, 5'h10);
    wait_idle();
    check("R6 write frame 2", obs_o, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h01, 5'h10, 2'b10, 16'h8001});
    rd(3'h4, v); check("R10 rx kept", {48'd0, v}, 64'h0001);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule